// File: doc/BRIEF.md
# Run-Time Configurable Signed/Unsigned Multiplier

This block multiplies two 16-bit operands for a DSP datapath. Control inputs chosen per operation set how the operands are read. A two-bit sign code selects one of three cases: both operands signed, both unsigned, or mixed, where operand A is signed and operand B is unsigned. A separate bit selects integer or fractional scaling. In fractional scaling the product is doubled, which removes the redundant sign bit of a Q15 × Q15 result.

The 32-bit result is widened to accumulator width (40 bits by default) so the following accumulate stage can take it directly. Modes that read operands as signed sign-extend the result. Unsigned mode zero-extends it. The fourth sign code is reserved: it raises an error flag and gives a zero product. The result and the flag are registered on every accepted operand pair and appear with an output strobe exactly one clock later. They hold their value until the next accepted pair.

Top module: `dsp_mul`

## Requirements
- R1: With sign_mode 2'b00 and int_mode 1, product[31:0] is the two's-complement product of opa and opb, both read as signed.
- R2: With sign_mode 2'b01 and int_mode 1, product[31:0] is the product of opa and opb, both read as unsigned.
- R3: With sign_mode 2'b10 and int_mode 1, product[31:0] is the product of opa read as signed and opb read as unsigned.
- R4: With int_mode 0 (fractional), product[31:0] is the low 32 bits of twice the exact product, with operands read as in R1 to R3.
- R5: With sign_mode 2'b00 and int_mode 0, opa = opb = 16'h8000 gives product 40'h007FFFFFFF instead of a negative value.
- R6: An accepted pair with sign_mode 2'b11 makes mode_err 1 and product 0. Any other accepted mode makes mode_err 0.
- R7: product[39:32] copies product[31] for sign_mode 2'b00 and 2'b10, and is zero for sign_mode 2'b01.
- R8: out_valid is 1 in exactly the cycle after a cycle with in_valid 1. product and mode_err in that cycle belong to that accepted pair.
- R9: While in_valid is 0, product and mode_err keep their last values.
- R10: While rst_n is 0, out_valid, mode_err and product are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair and controls are accepted this cycle |
| opa | input | 16 | Operand A |
| opb | input | 16 | Operand B |
| sign_mode | input | 2 | 00 signed, 01 unsigned, 10 A signed / B unsigned, 11 reserved |
| int_mode | input | 1 | 1 integer scaling, 0 fractional (product doubled) |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| product | output | 40 | Extended product |
| mode_err | output | 1 | Last accepted pair used the reserved sign code |

## Verification
The bench uses the default widths: 16-bit operands and a 40-bit result. At these widths the corner operands 16'h8000, 16'h7FFF and 16'hFFFF can be driven directly and their exact products can be worked out in 64-bit integers. This brings within reach the single fractional overflow case, the wrap in mixed and unsigned fractional results, and the edge between sign-extension and zero-extension. Runs of idle cycles between accepted pairs check that results hold, and random mode switching from pair to pair checks that no control setting carries over to the next operation.

// File: rtl/dsp_mul_pkg.sv
package dsp_mul_pkg;
  typedef enum logic [1:0] {
    SGN_BOTH  = 2'b00,
    SGN_NONE  = 2'b01,
    SGN_MIXED = 2'b10,
    SGN_RSVD  = 2'b11
  } sgn_mode_e;
endpackage

// File: rtl/dsp_mul_opext.sv
// Widens one operand by a bit, as signed or unsigned.
module dsp_mul_opext #(
  parameter int W = 16
) (
  input  logic [W-1:0]      opnd,
  input  logic              as_signed,
  output logic signed [W:0] ext
);
  always_comb begin
    ext = {as_signed & opnd[W-1], opnd};
  end
endmodule

// File: rtl/dsp_mul_core.sv
// Multiplies the widened operands, applies fractional doubling and the
// single positive-overflow fix.
module dsp_mul_core #(
  parameter int W  = 16,
  parameter int PW = 2 * W
) (
  input  logic signed [W:0] xa,
  input  logic signed [W:0] xb,
  input  logic              frac,
  input  logic              sat_case,
  output logic [PW-1:0]     res
);
  localparam logic [PW-1:0] POS_MAX = {1'b0, {(PW-1){1'b1}}};

  logic signed [PW-1:0] wa;
  logic signed [PW-1:0] wb;
  logic signed [PW-1:0] prod;
  logic [PW-1:0]        scaled;

  always_comb begin
    wa     = PW'(xa);
    wb     = PW'(xb);
    prod   = wa * wb;
    scaled = frac ? {prod[PW-2:0], 1'b0} : prod;
    res    = sat_case ? POS_MAX : scaled;
  end
endmodule

// File: rtl/dsp_mul_widen.sv
// Extends the product to accumulator width.
module dsp_mul_widen #(
  parameter int PW = 32,
  parameter int AW = 40
) (
  input  logic [PW-1:0] res,
  input  logic          zero_ext,
  output logic [AW-1:0] wide
);
  localparam int XW = AW - PW;

  generate
    if (XW > 0) begin : g_ext
      always_comb wide = {{XW{~zero_ext & res[PW-1]}}, res};
    end else begin : g_noext
      logic unused_ze;
      always_comb begin
        unused_ze = zero_ext;
        wide      = res[AW-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/dsp_mul.sv
module dsp_mul #(
  parameter int DW   = 16,
  parameter int ACCW = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [DW-1:0]   opa,
  input  logic [DW-1:0]   opb,
  input  logic [1:0]      sign_mode,
  input  logic            int_mode,
  output logic            out_valid,
  output logic [ACCW-1:0] product,
  output logic            mode_err
);
  import dsp_mul_pkg::*;

  localparam int PW = 2 * DW;
  localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

  sgn_mode_e          mode;
  logic               a_signed, b_signed, rsvd, frac, sat_case;
  logic signed [DW:0] xa, xb;
  logic [PW-1:0]      res;
  logic [ACCW-1:0]    wide;

  always_comb begin
    mode     = sgn_mode_e'(sign_mode);
    a_signed = (mode == SGN_BOTH) || (mode == SGN_MIXED);
    b_signed = (mode == SGN_BOTH);
    rsvd     = (mode == SGN_RSVD);
    frac     = ~int_mode;
    sat_case = (mode == SGN_BOTH) && frac && (opa == MOST_NEG) && (opb == MOST_NEG);
  end

  dsp_mul_opext #(.W(DW)) u_ext_a (.opnd(opa), .as_signed(a_signed), .ext(xa));
  dsp_mul_opext #(.W(DW)) u_ext_b (.opnd(opb), .as_signed(b_signed), .ext(xb));

  dsp_mul_core #(.W(DW), .PW(PW)) u_core (
    .xa(xa), .xb(xb), .frac(frac), .sat_case(sat_case), .res(res)
  );

  dsp_mul_widen #(.PW(PW), .AW(ACCW)) u_widen (
    .res(res), .zero_ext(mode == SGN_NONE), .wide(wide)
  );

  // next state
  logic            valid_d, err_d, ld_en;
  logic [ACCW-1:0] prod_d;

  always_comb begin
    valid_d = in_valid;
    ld_en   = in_valid;
    err_d   = rsvd;
    prod_d  = rsvd ? '0 : wide;
  end

  // registers
  logic            valid_q, err_q;
  logic [ACCW-1:0] prod_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      prod_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (ld_en) begin
        err_q  <= err_d;
        prod_q <= prod_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign product   = prod_q;
  assign mode_err  = err_q;
endmodule

// File: rtl/dsp_mul_chk.sv
module dsp_mul_chk #(
  parameter int DW   = 16,
  parameter int ACCW = 40
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [DW-1:0]   opa,
  input logic [DW-1:0]   opb,
  input logic [1:0]      sign_mode,
  input logic            int_mode,
  input logic            out_valid,
  input logic [ACCW-1:0] product,
  input logic            mode_err
);
  localparam int PW = 2 * DW;
  localparam logic [DW-1:0]   MOST_NEG = {1'b1, {(DW-1){1'b0}}};
  localparam logic [ACCW-1:0] SAT_VAL  = {{(ACCW-PW+1){1'b0}}, {(PW-1){1'b1}}};

  // R8
  strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R8
  no_spurious_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R6
  rsvd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sign_mode == 2'b11) |=> (mode_err && product == '0));

  // R6
  legal_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sign_mode != 2'b11) |=> !mode_err);

  // R5
  frac_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sign_mode == 2'b00 && !int_mode && opa == MOST_NEG && opb == MOST_NEG)
    |=> product == SAT_VAL);

  // R7
  zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sign_mode == 2'b01) |=> product[ACCW-1:PW] == '0);

  // R7
  sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (sign_mode == 2'b00 || sign_mode == 2'b10))
    |=> product[ACCW-1:PW] == {(ACCW-PW){product[PW-1]}});

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(product) && $stable(mode_err)));

  // R10
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (!out_valid && !mode_err && product == '0);
    end
  end
endmodule

bind dsp_mul dsp_mul_chk #(.DW(DW), .ACCW(ACCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
  .sign_mode(sign_mode), .int_mode(int_mode), .out_valid(out_valid),
  .product(product), .mode_err(mode_err)
);

// File: tb/tb_dsp_mul.sv
module tb_dsp_mul;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] opa, opb;
  logic [1:0]  sign_mode;
  logic        int_mode;
  logic        out_valid;
  logic [39:0] product;
  logic        mode_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  dsp_mul dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
    .sign_mode(sign_mode), .int_mode(int_mode), .out_valid(out_valid),
    .product(product), .mode_err(mode_err)
  );

  // reference state
  logic [39:0] e_prod;
  logic        e_err, e_valid;
  logic [1:0]  e_mode;
  string       e_tag;

  function automatic logic [39:0] ref_mul(logic [15:0] a, logic [15:0] b,
                                          logic [1:0] m, logic im);
    longint ea, eb, p;
    logic [31:0] r;
    if (m == 2'b11) return 40'd0;
    ea = (m == 2'b01) ? longint'(a) : longint'($signed(a));
    eb = (m == 2'b00) ? longint'($signed(b)) : longint'(b);
    p = ea * eb;
    if (!im) p = p * 2;
    if (m == 2'b00 && !im && a == 16'h8000 && b == 16'h8000) r = 32'h7FFF_FFFF;
    else r = p[31:0];
    if (m == 2'b01) return {8'h00, r};
    return {{8{r[31]}}, r};
  endfunction

  task automatic chk(string req, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare();
    chk("R8 out_valid", {39'd0, out_valid}, {39'd0, e_valid});
    chk("R6 mode_err", {39'd0, mode_err}, {39'd0, e_err});
    chk(e_tag, product, e_prod);
    if (e_valid && e_mode != 2'b11)
      chk("R7 extension", {32'd0, product[39:32]},
          {32'd0, (e_mode == 2'b01) ? 8'h00 : {8{e_prod[31]}}});
  endtask

  task automatic step(logic v, logic [15:0] a, logic [15:0] b, logic [1:0] m, logic im);
    @(negedge clk);
    compare();
    in_valid = v; opa = a; opb = b; sign_mode = m; int_mode = im;
    e_valid = v;
    if (v) begin
      e_prod = ref_mul(a, b, m, im);
      e_err  = (m == 2'b11);
      e_mode = m;
      if (m == 2'b11) e_tag = "R6 product";
      else if (m == 2'b00 && !im && a == 16'h8000 && b == 16'h8000) e_tag = "R5 product";
      else if (!im) e_tag = "R4 product";
      else if (m == 2'b00) e_tag = "R1 product";
      else if (m == 2'b01) e_tag = "R2 product";
      else e_tag = "R3 product";
    end else begin
      e_tag = "R9 product hold";
    end
  endtask

  function automatic logic [15:0] pick();
    case ($urandom_range(0, 5))
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'hFFFF;
      3: return 16'h0001;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    rst_n = 1'b0; in_valid = 1'b1; opa = 16'h1234; opb = 16'h5678;
    sign_mode = 2'b00; int_mode = 1'b1;
    e_prod = '0; e_err = 1'b0; e_valid = 1'b0; e_mode = 2'b00; e_tag = "R10 product";
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 out_valid", {39'd0, out_valid}, 40'd0);
    chk("R10 mode_err", {39'd0, mode_err}, 40'd0);
    chk("R10 product", product, 40'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    e_tag = "R10 product";

    step(1, 16'h8000, 16'h8000, 2'b00, 0);  // R5
    step(1, 16'h8000, 16'h8000, 2'b00, 1);  // R1
    step(1, 16'hFFFF, 16'hFFFF, 2'b01, 1);  // R2, R7 zero-ext with bit31 set
    step(1, 16'hFFFF, 16'hFFFF, 2'b01, 0);  // R4 unsigned wrap
    step(1, 16'h8000, 16'hFFFF, 2'b10, 1);  // R3
    step(1, 16'h7FFF, 16'hFFFF, 2'b10, 0);  // R4 mixed
    step(1, 16'h1234, 16'h5678, 2'b11, 1);  // R6
    step(0, 16'h0002, 16'h0003, 2'b00, 1);  // R9 hold of reserved result
    step(0, 16'h0002, 16'h0003, 2'b00, 1);
    step(1, 16'hFFFF, 16'h0001, 2'b00, 1);  // R1 negative, R7
    step(1, 16'h4000, 16'h4000, 2'b00, 0);  // R4 signed 0.5*0.5
    step(0, 16'h8000, 16'h8000, 2'b11, 0);  // R9
    step(1, 16'hC000, 16'h4000, 2'b00, 0);  // R4 negative fractional

    for (int i = 0; i < 4000; i++) begin
      step(($urandom_range(0, 3) != 0), pick(), pick(), 2'($urandom), 1'($urandom));
    end
    step(0, 16'h0, 16'h0, 2'b00, 1);
    step(0, 16'h0, 16'h0, 2'b00, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule